// File: doc/BRIEF.md
# Byte-Stream Packet Router with a Shared Spill Buffer

This block takes one stream of byte-wide packets and hands each packet to one of four output ports according to a destination byte at the head of the packet. A packet arrives as a destination byte, a source byte, a length byte, 1 to 63 payload bytes and a closing check byte. The check byte is the XOR of every byte before it in the packet. The whole packet, check byte included, is forwarded unchanged to the selected port. A mismatch in the check byte raises a single-cycle error pulse.

Each output port has its own FIFO of `DEPTH` bytes. One further FIFO of the same depth is kept in reserve. It is lent to the first port whose own FIFO is full and a byte for that port arrives. While lent, it takes every new byte for that port. The port drains its own FIFO before the lent one, so the byte order is kept. The spare returns to the pool as soon as it is empty. When the buffer that a byte needs has no room, a stall output goes high in the same cycle and the byte is not taken. The sender holds the byte until the stall output drops.

Top module: `pkt_router`

## Requirements
- R1: After reset all `out_ready` bits, `suspend` and `parity_err` are low and every `out_data` lane is zero.
- R2: A packet is destination, source, length (payload count in bits [5:0], bits [7:6] ignored), the payload, then a check byte. All of its bytes leave the selected port unchanged and in arrival order.
- R3: Bits [1:0] of the destination byte select the output port (0 to 3). No other port sees any byte of that packet.
- R4: Each port's own FIFO holds `DEPTH` bytes before that port needs the spare FIFO.
- R5: When a byte arrives for a port whose own FIFO is full and the spare FIFO is not lent, the spare is lent to that port. The port can then hold 2×`DEPTH` bytes.
- R6: While the spare is lent to a port, every new byte for that port goes into the spare. That port's reads empty its own FIFO before the spare.
- R7: The spare returns to the pool in the cycle it becomes empty. It can then be lent to any port, including a different one.
- R8: `suspend` is combinational. It is high exactly when `in_valid` is high and the buffer the current byte needs is full. A byte is taken on a clock edge only when `in_valid` is high and `suspend` is low.
- R9: Once a read frees an entry in the buffer that blocked the sender, `suspend` is low from the next cycle on.
- R10: `parity_err` is high for exactly the one cycle after a check byte is taken, and only when that byte differs from the XOR of the header and payload bytes of its packet.
- R11: `out_ready[p]` is high while port p has buffered bytes. A read while ready removes the oldest byte and shows it on lane p of `out_data` from the next cycle on. A read while not ready is ignored and the lane keeps its value.
- R12: While the spare is lent to one port, a byte for another port whose own FIFO is full raises `suspend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A packet byte is offered on `in_data` |
| in_data | input | W | Offered packet byte |
| suspend | output | 1 | The offered byte cannot be taken this cycle |
| parity_err | output | 1 | One-cycle pulse: check byte mismatch |
| out_ready | output | 4 | Per port: bytes are buffered |
| out_read | input | 4 | Per port: remove the oldest byte |
| out_data | output | 4×W | Per port lane: last byte removed, lane p at bits [p*W +: W] |

## Verification
The assertions rely on the sender behaving as a stalled source. While `suspend` is high it keeps `in_data` unchanged. The packets it offers are well formed, with a length of 1 to 63 and exactly that many payload bytes. The stimulus does this by offering each byte again every cycle until it is taken, and by building every packet from a length inside that range. The read strobes never depend on the design's outputs. They are set as fixed masks, applied every cycle or every fourth cycle, so reads of empty ports also occur.

// File: rtl/pkt_router.sv
module pkt_router #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    in_data,
  output logic            suspend,
  output logic            parity_err,
  output logic [3:0]      out_ready,
  input  logic [3:0]      out_read,
  output logic [4*W-1:0]  out_data
);
  localparam int NP = 4;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_DST, S_SRC, S_LEN, S_PAY, S_TAIL} st_t;

  st_t          st;
  logic [5:0]   left;
  logic [W-1:0] par;
  logic [1:0]   cur;
  logic         perr;

  logic [W-1:0]  fmem [DEPTH];
  logic [AW-1:0] fwp, frp;
  logic [CW-1:0] fcnt, fnext;
  logic          own_v;
  logic [1:0]    own;

  logic [NP-1:0] s_full, s_emp;
  logic [1:0]    pn;
  logic          to_float, room, acc, wr_f, rd_f;
  logic [W-1:0]  fhead;

  assign pn       = (st == S_DST) ? in_data[1:0] : cur;
  assign to_float = own_v && own == pn;
  assign room     = to_float ? (fcnt != CW'(DEPTH)) : (!s_full[pn] || !own_v);
  assign suspend  = in_valid && !room;
  assign acc      = in_valid && room;
  assign wr_f     = acc && (to_float || s_full[pn]);
  assign rd_f     = own_v && out_read[own] && s_emp[own] && fcnt != '0;
  assign fhead    = fmem[frp];
  assign fnext    = fcnt + CW'(wr_f) - CW'(rd_f);
  assign parity_err = perr;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [W-1:0]  dq;
    logic          wr, rd;

    assign wr        = acc && !wr_f && pn == 2'(p);
    assign rd        = out_read[p] && cnt != '0;
    assign s_full[p] = cnt == CW'(DEPTH);
    assign s_emp[p]  = cnt == '0;
    assign out_ready[p] = !s_emp[p] || (own_v && own == 2'(p) && fcnt != '0);
    assign out_data[p*W +: W] = dq;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0; dq <= '0;
      end else begin
        if (wr) begin
          mem[wp] <= in_data;
          wp <= wp + 1'b1;
        end
        if (rd) begin
          dq <= mem[rp];
          rp <= rp + 1'b1;
        end else if (rd_f && own == 2'(p)) begin
          dq <= fhead;
        end
        cnt <= cnt + CW'(wr) - CW'(rd);
      end
    end

    a_r11_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready[p] && !out_read[p]) |=> out_ready[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwp <= '0; frp <= '0; fcnt <= '0; own_v <= 1'b0; own <= '0;
    end else begin
      if (wr_f) begin
        fmem[fwp] <= in_data;
        fwp <= fwp + 1'b1;
      end
      if (rd_f) frp <= frp + 1'b1;
      fcnt <= fnext;
      if (wr_f && !own_v) begin
        own_v <= 1'b1;
        own   <= pn;
      end else if (own_v && fnext == '0) begin
        own_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_DST; left <= '0; par <= '0; cur <= '0; perr <= 1'b0;
    end else begin
      perr <= 1'b0;
      if (acc) begin
        case (st)
          S_DST: begin cur <= in_data[1:0]; par <= in_data; st <= S_SRC; end
          S_SRC: begin par <= par ^ in_data; st <= S_LEN; end
          S_LEN: begin
            par  <= par ^ in_data;
            left <= in_data[5:0];
            st   <= (in_data[5:0] == '0) ? S_TAIL : S_PAY;
          end
          S_PAY: begin
            par  <= par ^ in_data;
            left <= left - 1'b1;
            if (left == 6'd1) st <= S_TAIL;
          end
          S_TAIL: begin perr <= in_data != par; st <= S_DST; end
          default: st <= S_DST;
        endcase
      end
    end
  end

  a_r7_spare_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt != '0) |-> own_v);

  a_r7_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && $past(own_v)) |-> $stable(own));

  a_r6_static_first: assert property (@(posedge clk) disable iff (!rst_n)
    (own_v && !s_emp[own] && !wr_f) |=> fcnt == $past(fcnt));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> !perr);

  a_r8_stall_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && out_read == '0) |=> (!in_valid || !$stable(in_data) || suspend));
endmodule

// File: tb/test_pkt_router.sv
`timescale 1ns/1ps
module test_pkt_router;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        suspend, parity_err;
  logic [3:0]  out_ready, out_read;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  pkt_router #(.W(8), .DEPTH(D)) i_pkt_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .suspend(suspend), .parity_err(parity_err), .out_ready(out_ready),
    .out_read(out_read), .out_data(out_data));

  int checks = 0, errors = 0, tick = 0;
  int rd_mode = 0;
  logic [3:0] rd_mask = 4'h0;
  bit last_acc;

  int m_st[4];
  int m_fl = 0, m_own = -1;
  logic [7:0] q [4][$];
  logic [7:0] exp_data [4];
  logic exp_perr = 1'b0;
  int mstate = 0, mcnt = 0, mport = 0;
  logic [7:0] mpar = 8'h00;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at tick %0d", req, act, exp, tick);
    end
  endtask

  function automatic bit mready(int p);
    return m_st[p] > 0 || (m_own == p && m_fl > 0);
  endfunction

  task automatic cyc(input logic v, input logic [7:0] d);
    logic [3:0] rd;
    int pn;
    bit room, tof, tgt_f, acc;
    tick++;
    rd = (rd_mode == 1 || (rd_mode == 2 && tick % 4 == 0)) ? rd_mask : 4'h0;
    in_valid = v; in_data = d; out_read = rd;
    #1;
    pn   = (mstate == 0) ? int'(d[1:0]) : mport;
    tof  = (m_own == pn);
    room = tof ? (m_fl < D) : (m_st[pn] < D || m_own < 0);
    chk("R4 R5 R8 R9 R12 suspend", {31'd0, suspend}, {31'd0, v && !room});
    acc = v && room;
    last_acc = acc;
    tgt_f = tof || m_st[pn] >= D;
    @(posedge clk);
    for (int p = 0; p < 4; p++)
      if (rd[p] && mready(p)) begin
        exp_data[p] = q[p].pop_front();
        if (m_st[p] > 0) m_st[p]--; else m_fl--;
      end
    if (acc) begin
      q[pn].push_back(d);
      if (tgt_f) begin
        if (m_own < 0) m_own = pn;
        m_fl++;
      end else m_st[pn]++;
    end
    if (m_own >= 0 && m_fl == 0) m_own = -1;
    exp_perr = 1'b0;
    if (acc) begin
      case (mstate)
        0: begin mport = int'(d[1:0]); mpar = d; mstate = 1; end
        1: begin mpar ^= d; mstate = 2; end
        2: begin mpar ^= d; mcnt = int'(d[5:0]); mstate = (mcnt == 0) ? 4 : 3; end
        3: begin mpar ^= d; mcnt--; if (mcnt == 0) mstate = 4; end
        default: begin exp_perr = (d != mpar); mstate = 0; end
      endcase
    end
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      chk("R7 R11 ready", {31'd0, out_ready[p]}, {31'd0, mready(p)});
      chk("R2 R3 R6 R11 data", {24'd0, out_data[p*8 +: 8]}, {24'd0, exp_data[p]});
    end
    chk("R10 parity", {31'd0, parity_err}, {31'd0, exp_perr});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00);
  endtask

  task automatic send_pkt(input int dst, input int len, input bit bad);
    logic [7:0] b[$];
    logic [7:0] x;
    b.push_back(8'h40 | 8'(dst));
    b.push_back(8'h11 + 8'(dst));
    b.push_back({2'b10, 6'(len)});
    for (int i = 0; i < len; i++) b.push_back(8'(dst * 31 + i * 7 + len));
    x = 8'h00;
    foreach (b[i]) x ^= b[i];
    b.push_back(x ^ (bad ? 8'h01 : 8'h00));
    foreach (b[i]) begin
      cyc(1'b1, b[i]);
      while (!last_acc) cyc(1'b1, b[i]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 4; p++) begin m_st[p] = 0; exp_data[p] = 8'h00; end
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_read = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {28'd0, out_ready}, 32'd0);
    chk("R1 suspend", {31'd0, suspend}, 32'd0);
    chk("R1 parity", {31'd0, parity_err}, 32'd0);
    chk("R1 data", out_data, 32'd0);

    rd_mode = 0;
    send_pkt(2, 3, 1'b0);
    idle(2);
    rd_mode = 1; rd_mask = 4'hF;
    idle(10);

    rd_mode = 2;
    for (int p = 0; p < 4; p++) send_pkt(p, p * 5 + 1, 1'b0);
    idle(40);

    send_pkt(1, 5, 1'b1);
    idle(20);

    rd_mode = 2; rd_mask = 4'h8;
    send_pkt(3, 63, 1'b0);
    rd_mode = 1;
    idle(120);

    rd_mode = 0;
    send_pkt(0, 28, 1'b0);
    rd_mode = 2; rd_mask = 4'h1;
    send_pkt(1, 25, 1'b0);
    rd_mode = 1; rd_mask = 4'hF;
    idle(80);

    finish_run();
  end
endmodule